// File: doc/BRIEF.md
# Sequential Second-Order IIR Section with Doubling Flags

This block filters a stream of 16-bit fractional samples through one second-order recursive section. Each output needs five products: three feed-forward taps on the present and two previous inputs, and two feedback taps on the two previous outputs. The block forms all five in turn on one unsigned 16x16 multiplier. The sign of each product is applied after the multiply. The products are summed in a 40-bit accumulator. The sum is then clipped to the signed 32-bit range, and its upper half becomes the 16-bit output. Samples and coefficients use the scale where 32767 stands for 1.0.

The coefficients sit in a small register file in sign-magnitude form. The leading coefficient of the recursive part is fixed at 1.0, so its slot holds a flag word instead of a value. Each flag doubles the product of one coefficient, which lets that coefficient reach magnitudes just below 2.0. A host loads the coefficients, then pulses `start` with a sample while the block is idle. It collects `y_out` when `done` pulses.

The sequencer has four states:
- `ST_IDLE` waits for `start`.
- `ST_MAC` runs the five multiply-accumulate steps.
- `ST_SAT` clips the sum and registers the output.
- `ST_DONE` raises `done` and advances the delay line.

Its transitions are:
- accept (`ST_IDLE` to `ST_MAC`, on `start`).
- last-tap (`ST_MAC` to `ST_SAT`, after tap 4).
- narrow (`ST_SAT` to `ST_DONE`).
- retire (`ST_DONE` to `ST_IDLE`).

Top module: `sos_mac_filter`

## Requirements
- R1: After reset, `y_out` is 0, `busy` is 0 and `done` is 0. All coefficients, flags and delay values are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr`. The coefficient addresses are 0=b0, 1=b1, 2=b2, 3=a1 and 4=a2. In each coefficient word, bit 15 is the sign (1 = negative) and bits 14:0 are the magnitude, with 32767 standing for 1.0.
- R3: Each output is the upper 16 bits (bits 31:16) of the clipped sum S = b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2].
  - Each term is computed as |data|·|coef|·2^(1+f).
  - Its sign is the XOR of the data sign, the coefficient sign, and 1 for the two feedback taps.
- R4: Address 5 holds the doubling flags. Bit k (b0=bit 0, b1=bit 1, b2=bit 2, a1=bit 3, a2=bit 4) sets f=1 for coefficient k. Bits 15:5 of that word have no effect.
- R5: A sum above 2^31−1 is clipped to 2^31−1, which gives `y_out` = 0x7FFF. A sum below −2^31 is clipped to −2^31, which gives `y_out` = 0x8000.
- R6: `done` is high for exactly one cycle. It rises on the seventh falling clock edge after `start` is raised, that is six rising edges after the edge that accepts the sample. `y_out` is valid from that cycle and holds until the next output.
- R7: A `start` that arrives while `busy` is high has no effect. It changes neither the result nor the delay line, and it does not begin another computation.
- R8: After each `done`, the delay line advances: x[n-2]←x[n-1], x[n-1]←x[n], y[n-2]←y[n-1], y[n-1]←y[n].
- R9: `busy` is high from the cycle after acceptance through the `done` cycle inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient or flag write strobe |
| cfg_addr | input | 3 | Write address (0-4 coefficients, 5 flags) |
| cfg_wdata | input | 16 | Sign-magnitude coefficient or flag word |
| start | input | 1 | Accept `x_in` when idle |
| x_in | input | 16 | Signed input sample |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse, output ready |
| y_out | output | 16 | Signed filtered output |

## Verification
The assertions check four properties on every cycle:
- `done` never lasts two cycles, and `busy` is always high with it.
- An accepted sample always raises `busy`, and the captured sample stays frozen while the block is busy.
- The tap index stays within range.
- The clipped word never takes a sign opposite to the accumulator.

Numerical correctness can only be shown by the bench's scenarios, which compare every output with an integer model. These cover the mapping from flag bit to coefficient, sign-magnitude corner values (including negative zero), clipping in both directions under an overshooting step, the exact latency, and the rejection of starts that arrive mid-computation.

// File: rtl/sos_pkg.sv
package sos_pkg;
    localparam int TAP_COUNT   = 5;
    localparam int TAP_IDX_W   = $clog2(TAP_COUNT);
    localparam int FB_FIRST    = 3;
    localparam int FLAG_ADDR   = TAP_COUNT;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_SAT,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/sos_coef_bank.sv
module sos_coef_bank #(
    parameter int COEF_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [COEF_W-1:0]                   wr_data,
    input  logic [sos_pkg::TAP_IDX_W-1:0]       rd_idx,
    output logic [COEF_W-2:0]                   rd_mag,
    output logic                                rd_neg,
    output logic                                rd_dbl
);
    import sos_pkg::*;

    localparam int FLAT_W = TAP_COUNT * COEF_W;

    logic [FLAT_W-1:0]    coef_flat;
    logic [TAP_COUNT-1:0] flag_q;
    logic [COEF_W-1:0]    coef_word;

    // one storage word per tap
    for (genvar gi = 0; gi < TAP_COUNT; gi++) begin : g_tap
        logic [COEF_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(gi))
                word_q <= wr_data;
        end
        assign coef_flat[gi*COEF_W +: COEF_W] = word_q;
    end

    // the unity slot carries the doubling flags
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(FLAG_ADDR))
            flag_q <= wr_data[TAP_COUNT-1:0];
    end

    always_comb begin
        coef_word = '0;
        rd_dbl    = 1'b0;
        for (int k = 0; k < TAP_COUNT; k++) begin
            if (rd_idx == TAP_IDX_W'(k)) begin
                coef_word = coef_flat[k*COEF_W +: COEF_W];
                rd_dbl    = flag_q[k];
            end
        end
    end

    assign rd_neg = coef_word[COEF_W-1];
    assign rd_mag = coef_word[COEF_W-2:0];
endmodule

// File: rtl/sos_seq_fsm.sv
module sos_seq_fsm (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    output logic                          acc_clr,
    output logic                          mac_en,
    output logic                          sat_en,
    output logic                          shift_en,
    output logic [sos_pkg::TAP_IDX_W-1:0] tap_idx
);
    import sos_pkg::*;

    seq_state_t             state_q, state_d;
    logic [TAP_IDX_W-1:0]   idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_MAC;
                    idx_d   = '0;
                end
            end
            ST_MAC: begin
                if (idx_q == TAP_IDX_W'(TAP_COUNT - 1))
                    state_d = ST_SAT;
                else
                    idx_d = idx_q + TAP_IDX_W'(1);
            end
            ST_SAT:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        acc_clr  = (state_q == ST_IDLE) && start;
        mac_en   = (state_q == ST_MAC);
        sat_en   = (state_q == ST_SAT);
        done     = (state_q == ST_DONE);
        shift_en = (state_q == ST_DONE);
        tap_idx  = idx_q;
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> busy);

    // R3
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_en |-> (tap_idx < TAP_IDX_W'(TAP_COUNT)));
endmodule

// File: rtl/sos_mac_unit.sv
module sos_mac_unit #(
    parameter int SMP_W  = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 40,
    parameter int SAT_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_clr,
    input  logic                     mac_en,
    input  logic signed [SMP_W-1:0]  sample,
    input  logic [COEF_W-2:0]        coef_mag,
    input  logic                     coef_neg,
    input  logic                     coef_dbl,
    input  logic                     sub_term,
    output logic [SAT_W-1:0]         sat_word
);
    localparam int PROD_W = SMP_W + COEF_W;
    localparam int SH_W   = PROD_W + 2;

    logic [SMP_W-1:0]         samp_mag;
    logic [PROD_W-1:0]        prod;
    logic [SH_W-1:0]          prod_sh;
    logic                     term_neg;
    logic signed [ACC_W-1:0]  mag_ext;
    logic signed [ACC_W-1:0]  addend;
    logic signed [ACC_W-1:0]  acc_q;
    logic                     ovf;

    always_comb begin
        samp_mag = sample[SMP_W-1] ? SMP_W'(-sample) : SMP_W'(sample);
        prod     = PROD_W'(samp_mag) * PROD_W'({1'b0, coef_mag});
        // base shift aligns Q30 to Q31; flag adds one more
        prod_sh  = coef_dbl ? {prod, 2'b00} : {1'b0, prod, 1'b0};
        term_neg = sample[SMP_W-1] ^ coef_neg ^ sub_term;
        mag_ext  = ACC_W'(prod_sh);
        addend   = term_neg ? -mag_ext : mag_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (acc_clr)
            acc_q <= '0;
        else if (mac_en)
            acc_q <= acc_q + addend;
    end

    always_comb begin
        ovf = (|acc_q[ACC_W-1:SAT_W-1]) & ~(&acc_q[ACC_W-1:SAT_W-1]);
        if (ovf)
            sat_word = acc_q[ACC_W-1] ? {1'b1, {(SAT_W-1){1'b0}}}
                                      : {1'b0, {(SAT_W-1){1'b1}}};
        else
            sat_word = acc_q[SAT_W-1:0];
    end

    // R5
    sat_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_word[SAT_W-1] == acc_q[ACC_W-1]);
endmodule

// File: rtl/sos_mac_filter.sv
module sos_mac_filter #(
    parameter int SMP_W  = 16,
    parameter int COEF_W = 16,
    parameter int ADDR_W = 3,
    parameter int ACC_W  = 40,
    parameter int SAT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic [SMP_W-1:0]  x_in,
    output logic              busy,
    output logic              done,
    output logic [SMP_W-1:0]  y_out
);
    import sos_pkg::*;

    logic                        acc_clr, mac_en, sat_en, shift_en;
    logic [TAP_IDX_W-1:0]        tap_idx;
    logic [COEF_W-2:0]           coef_mag;
    logic                        coef_neg, coef_dbl;
    logic signed [SMP_W-1:0]     operand;
    logic                        sub_term;
    logic [SAT_W-1:0]            sat_word;
    logic [SMP_W-1:0]            x_cur_q, x1_q, x2_q, y1_q, y2_q, y_q;
    logic                        unused_sat_lo;

    sos_seq_fsm u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .acc_clr  (acc_clr),
        .mac_en   (mac_en),
        .sat_en   (sat_en),
        .shift_en (shift_en),
        .tap_idx  (tap_idx)
    );

    sos_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_idx  (tap_idx),
        .rd_mag  (coef_mag),
        .rd_neg  (coef_neg),
        .rd_dbl  (coef_dbl)
    );

    // operand order follows the tap index: x, x1, x2, y1, y2
    always_comb begin
        unique case (tap_idx)
            TAP_IDX_W'(0): operand = x_cur_q;
            TAP_IDX_W'(1): operand = x1_q;
            TAP_IDX_W'(2): operand = x2_q;
            TAP_IDX_W'(3): operand = y1_q;
            default:       operand = y2_q;
        endcase
        sub_term = (tap_idx >= TAP_IDX_W'(FB_FIRST));
    end

    sos_mac_unit #(
        .SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SAT_W(SAT_W)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_clr  (acc_clr),
        .mac_en   (mac_en),
        .sample   (operand),
        .coef_mag (coef_mag),
        .coef_neg (coef_neg),
        .coef_dbl (coef_dbl),
        .sub_term (sub_term),
        .sat_word (sat_word)
    );

    assign unused_sat_lo = ^sat_word[SAT_W-SMP_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_cur_q <= '0;
            x1_q    <= '0;
            x2_q    <= '0;
            y1_q    <= '0;
            y2_q    <= '0;
            y_q     <= '0;
        end else begin
            if (acc_clr)
                x_cur_q <= x_in;
            if (sat_en)
                y_q <= sat_word[SAT_W-1 -: SMP_W];
            if (shift_en) begin
                x2_q <= x1_q;
                x1_q <= x_cur_q;
                y2_q <= y1_q;
                y1_q <= y_q;
            end
        end
    end

    assign y_out = y_q;

    // R7
    xcap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(x_cur_q));

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

// File: tb/sos_mac_filter_tb_top.sv
module sos_mac_filter_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_addr = '0;
    logic [15:0]        cfg_wdata = '0;
    logic               start = 1'b0;
    logic [15:0]        x_in = '0;
    logic               busy, done;
    logic [15:0]        y_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    logic [15:0] m_coef [5];
    logic [4:0]  m_flag;
    longint      mx1, mx2, my1, my2;

    always #4 clk = ~clk;

    sos_mac_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .x_in(x_in),
        .busy(busy), .done(done), .y_out(y_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint term(input longint d, input logic [15:0] c,
                                    input bit f, input bit fb);
        longint m;
        longint p;
        bit     neg;
        m   = (d < 0) ? -d : d;
        p   = m * longint'(c[14:0]);
        p   = p <<< (1 + f);
        neg = (d < 0) ^ c[15] ^ fb;
        return neg ? -p : p;
    endfunction

    task automatic model_step(input longint x, output longint y);
        longint s;
        s = term(x,   m_coef[0], m_flag[0], 1'b0)
          + term(mx1, m_coef[1], m_flag[1], 1'b0)
          + term(mx2, m_coef[2], m_flag[2], 1'b0)
          + term(my1, m_coef[3], m_flag[3], 1'b1)
          + term(my2, m_coef[4], m_flag[4], 1'b1);
        if (s > 64'sd2147483647)  s = 64'sd2147483647;
        if (s < -64'sd2147483648) s = -64'sd2147483648;
        y   = s >>> 16;
        mx2 = mx1; mx1 = x;
        my2 = my1; my1 = y;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) m_coef[i] = '0;
        m_flag = '0;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 3'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 5) m_coef[addr] = data;
        else if (addr == 5) m_flag = data[4:0];
    endtask

    function automatic longint sx(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic run_sample(input longint x, input string req, output longint y);
        int     lat;
        bit     busy_ok;
        longint yexp;
        @(negedge clk);
        start = 1'b1;
        x_in  = 16'(x);
        lat = 0;
        busy_ok = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (!busy) busy_ok = 1'b0;
            if (done) begin
                lat = k;
                break;
            end
        end
        check("R6 latency", lat, 7);
        check("R9 busy while computing", busy_ok, 1);
        y = sx(y_out);
        model_step(x, yexp);
        check(req, y, yexp);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 y_out", y_out, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
    endtask

    task automatic t_impulse();
        longint y;
        do_reset();
        wr(0, 16'h4000);
        wr(1, 16'h2000);
        wr(2, 16'h9000);
        wr(3, 16'hC000);
        wr(4, 16'h2000);
        wr(5, 16'h0010);
        run_sample(16384, "R3 impulse", y);
        for (int i = 0; i < 6; i++) run_sample(0, "R8 impulse tail", y);
        run_sample(-12000, "R3 mixed", y);
        run_sample(30000, "R3 mixed", y);
        run_sample(-32768, "R3 mixed", y);
    endtask

    task automatic t_flags();
        longint y;
        do_reset();
        wr(0, 16'h4000);
        run_sample(8192, "R4 no flag", y);
        check("R4 unflagged value", y, 4096);
        wr(5, 16'h0001);
        run_sample(8192, "R4 flag b0", y);
        check("R4 doubled value", y, 8192);
        wr(5, 16'hFFFE);
        run_sample(8192, "R4 upper flag bits", y);
        check("R4 other flags ignored for b0", y, 4096);
        do_reset();
        wr(1, 16'h4000);
        wr(5, 16'h0002);
        run_sample(8192, "R4 b1 first", y);
        run_sample(0, "R4 flag b1", y);
        check("R4 flag bit1 doubles b1", y, 8192);
    endtask

    task automatic t_signmag();
        longint y;
        do_reset();
        wr(0, 16'hA000);
        run_sample(-20000, "R2 neg x neg coef", y);
        check("R2 sign-magnitude product", y, 5000);
        wr(0, 16'h8000);
        run_sample(12345, "R2 negative zero", y);
        check("R2 negative zero coef", y, 0);
    endtask

    task automatic t_saturate();
        longint y;
        do_reset();
        wr(0, 16'h7FFF);
        wr(3, 16'hE000);
        wr(5, 16'h0009);
        for (int i = 0; i < 4; i++) begin
            run_sample(32767, "R5 positive step", y);
            check("R5 clip high", y, 32767);
        end
        for (int i = 0; i < 4; i++) run_sample(-32768, "R5 negative step", y);
        check("R5 clip low", y, -32768);
    endtask

    task automatic t_ignore();
        longint yexp;
        longint y;
        bit     busy_ok;
        int     dcount;
        do_reset();
        wr(0, 16'h4000);
        wr(1, 16'h6000);
        wr(3, 16'h2000);
        @(negedge clk);
        start = 1'b1;
        x_in = 16'd1000;
        busy_ok = 1'b1;
        dcount = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k == 3 || k == 7) begin
                start = 1'b1;
                x_in = 16'hC000;
            end
            if (k <= 7 && !busy) busy_ok = 1'b0;
            if (done) dcount++;
            if (k == 7) y = sx(y_out);
            if (k == 8) begin
                check("R7 no restart after late start", busy, 0);
                check("R7 no extra done", done, 0);
            end
        end
        start = 1'b0;
        check("R9 busy held", busy_ok, 1);
        check("R7 single done", dcount, 1);
        model_step(1000, yexp);
        check("R7 result unchanged", y, yexp);
        run_sample(-500, "R7 delay line shifted once", y);
        run_sample(0, "R8 after ignored start", y);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_impulse();
        t_flags();
        t_signmag();
        t_saturate();
        t_ignore();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule